// File: doc/BRIEF.md
# Timer Compare Unit with Event Trigger

This block pairs a free-running 16-bit timer with a 16-bit compare register. Every clock it tests the two for equality, and the first cycle they become equal counts as one match. A 4-bit mode field sets what a match does. It can toggle, set or clear a compare output latch. It can raise only the interrupt flag. Or it can issue a special event trigger, which restarts the timer and requests an ADC conversion. In trigger mode the compare register works as a programmable period: with ticks on every cycle the timer counts from 0 up to the compare value and then returns to 0.

The trigger request is a combinational pulse in the cycle of the match. The timer restart waits for the next tick, so a tick that comes later still restarts it. If software rewrites the compare register before that tick, the restart is dropped. The timer, compare register and mode field load through plain write strobes. The interrupt and overflow flags are sticky and have their own clear strobes. The block has no streaming data path, so every pin is a plain control or status signal.

Top module: `cmpt_unit`

## Requirements
- R1: A match fires once when the timer value becomes equal to the compare value. While the timer is held at that value (tick enable low) the match does not fire again.
- R2: In mode 0010 each match inverts the compare output latch, and the pin-drive enable is high.
- R3: In mode 1000 a match sets the latch to 1. In mode 1001 a match clears it to 0. In both modes the pin-drive enable is high.
- R4: In every listed mode (0010, 1000, 1001, 1010, 1011) a match sets the interrupt flag on the clock edge that follows the match cycle. The flag stays set until an interrupt-clear strobe arrives.
- R5: Writing 0000 to the mode field forces the compare output latch low on the next edge.
- R6: In mode 1010 a match sets only the interrupt flag. The latch keeps its value and the pin-drive enable is low.
- R7: In mode 1011 the ADC start output is high during the match cycle itself, but only when the ADC enable input is high. The pin-drive enable is low and the latch keeps its value.
- R8: After a mode-1011 match the timer loads 0 on the next edge at which tick enable is high. This is either the edge that ends the match cycle or a later edge.
- R9: A compare-register write made after a mode-1011 match and before the next tick cancels the pending restart, so the timer increments normally.
- R10: A tick at timer value FFFF wraps the timer to 0000 and sets the overflow flag, which stays set until an overflow-clear strobe. A restart caused by the trigger never sets the overflow flag.
- R11: Any unlisted mode value disables the compare function: no latch change, no interrupt, pin-drive enable low.
- R12: The timer advances by one only on edges with tick enable high. A timer write loads the written value and takes priority over ticks and restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Timer advance enable for this edge |
| tmr_wr_en | input | 1 | Timer load strobe |
| tmr_wr_data | input | 16 | Timer load value |
| cmp_wr_en | input | 1 | Compare register write strobe |
| cmp_wr_data | input | 16 | Compare register write value |
| ctl_wr_en | input | 1 | Mode field write strobe |
| ctl_wr_data | input | 4 | Mode field write value |
| adc_en | input | 1 | Allows the ADC start pulse in trigger mode |
| irq_clr | input | 1 | Clears the interrupt flag |
| ovf_clr | input | 1 | Clears the overflow flag |
| tmr_value | output | 16 | Current timer value |
| cmp_out | output | 1 | Compare output latch |
| pin_oe | output | 1 | Pin-drive enable |
| irq_flag | output | 1 | Sticky compare interrupt flag |
| ovf_flag | output | 1 | Sticky timer overflow flag |
| adc_start | output | 1 | ADC start request pulse |

## Verification
The hardest state to reach is a pending trigger restart: a mode-1011 match has occurred, but no tick has come yet to consume it. The stimulus reaches this state by dropping tick enable in the match cycle itself. It then holds the timer for several cycles before it either supplies the tick, to see the restart to 0, or rewrites the compare register first, to see the cancel. The same hold also shows that a timer parked on the matching value raises the interrupt only once.

// File: rtl/cmpt_pkg.sv
package cmpt_pkg;
  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    CM_OFF    = 4'b0000,
    CM_TOGGLE = 4'b0010,
    CM_SET    = 4'b1000,
    CM_CLEAR  = 4'b1001,
    CM_IRQ    = 4'b1010,
    CM_TRIG   = 4'b1011
  } cmp_mode_e;

  function automatic logic mode_known(input logic [MODE_W-1:0] m);
    return (m == CM_TOGGLE) || (m == CM_SET) || (m == CM_CLEAR) ||
           (m == CM_IRQ) || (m == CM_TRIG);
  endfunction

  function automatic logic mode_drives_pin(input logic [MODE_W-1:0] m);
    return (m == CM_TOGGLE) || (m == CM_SET) || (m == CM_CLEAR);
  endfunction
endpackage

// File: rtl/cmpt_timer.sv
module cmpt_timer #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             ld_en,
  input  logic [TMR_W-1:0] ld_data,
  input  logic             trig_evt,
  input  logic             cancel,
  input  logic             ovf_clr,
  output logic [TMR_W-1:0] tmr_q,
  output logic             ovf_flag
);
  localparam logic [TMR_W-1:0] TMR_MAX = {TMR_W{1'b1}};
  localparam logic [TMR_W-1:0] TMR_ONE = {{(TMR_W-1){1'b0}}, 1'b1};

  logic pend_q;
  logic restart;
  logic wrap;

  assign restart = (pend_q | trig_evt) & ~cancel;
  assign wrap    = ~ld_en & tick_en & ~restart & (tmr_q == TMR_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q  <= '0;
      pend_q <= 1'b0;
    end else if (ld_en) begin
      tmr_q  <= ld_data;
      pend_q <= 1'b0;
    end else if (tick_en) begin
      tmr_q  <= restart ? '0 : tmr_q + TMR_ONE;
      pend_q <= 1'b0;
    end else begin
      pend_q <= restart;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovf_flag <= 1'b0;
    else if (wrap)    ovf_flag <= 1'b1;
    else if (ovf_clr) ovf_flag <= 1'b0;
  end

  AST_TICK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !ld_en) |=> $stable(tmr_q)); // R12
  AST_TRIG_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !ld_en && pend_q && !cancel) |=> (tmr_q == '0)); // R8
  AST_CANCEL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (cancel && !ld_en && !tick_en) |=> !pend_q); // R9
  AST_OVF_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> ($past(tmr_q) == TMR_MAX)); // R10
endmodule

// File: rtl/cmpt_match.sv
module cmpt_match #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TMR_W-1:0] tmr_q,
  input  logic [TMR_W-1:0] cmp_q,
  output logic             hit
);
  logic equal;
  logic equal_d;

  assign equal = (tmr_q == cmp_q);
  assign hit   = equal & ~equal_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) equal_d <= 1'b0;
    else        equal_d <= equal;
  end

  AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !hit); // R1
endmodule

// File: rtl/cmpt_action.sv
module cmpt_action
  import cmpt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr_en,
  input  logic [MODE_W-1:0] ctl_wr_data,
  input  logic              hit,
  input  logic              adc_en,
  input  logic              irq_clr,
  output logic              out_q,
  output logic              pin_oe,
  output logic              irq_flag,
  output logic              adc_start,
  output logic              trig_evt
);
  logic [MODE_W-1:0] mode_q;
  logic              evt;
  logic              out_nxt;

  assign evt       = hit & mode_known(mode_q);
  assign trig_evt  = evt & (mode_q == CM_TRIG);
  assign adc_start = trig_evt & adc_en;
  assign pin_oe    = mode_drives_pin(mode_q);

  always_comb begin
    out_nxt = out_q;
    if (evt) begin
      case (mode_q)
        CM_TOGGLE: out_nxt = ~out_q;
        CM_SET:    out_nxt = 1'b1;
        CM_CLEAR:  out_nxt = 1'b0;
        default:   out_nxt = out_q;
      endcase
    end
    if (ctl_wr_en && (ctl_wr_data == CM_OFF)) out_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= CM_OFF;
      out_q  <= 1'b0;
    end else begin
      out_q <= out_nxt;
      if (ctl_wr_en) mode_q <= ctl_wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq_flag <= 1'b0;
    else if (evt)     irq_flag <= 1'b1;
    else if (irq_clr) irq_flag <= 1'b0;
  end

  AST_LATCH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr_en && ctl_wr_data == CM_OFF) |=> !out_q); // R5
  AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> irq_flag); // R4
  AST_SWI_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == CM_IRQ && !ctl_wr_en) |=> $stable(out_q)); // R6
  AST_UNKNOWN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_known(mode_q) && !irq_flag) |=> !irq_flag); // R11
endmodule

// File: rtl/cmpt_unit.sv
module cmpt_unit
  import cmpt_pkg::*;
#(
  parameter int TMR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              tmr_wr_en,
  input  logic [TMR_W-1:0]  tmr_wr_data,
  input  logic              cmp_wr_en,
  input  logic [TMR_W-1:0]  cmp_wr_data,
  input  logic              ctl_wr_en,
  input  logic [MODE_W-1:0] ctl_wr_data,
  input  logic              adc_en,
  input  logic              irq_clr,
  input  logic              ovf_clr,
  output logic [TMR_W-1:0]  tmr_value,
  output logic              cmp_out,
  output logic              pin_oe,
  output logic              irq_flag,
  output logic              ovf_flag,
  output logic              adc_start
);
  logic [TMR_W-1:0] cmp_q;
  logic [TMR_W-1:0] tmr_q;
  logic             hit;
  logic             trig_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cmp_q <= {TMR_W{1'b1}};
    else if (cmp_wr_en) cmp_q <= cmp_wr_data;
  end

  cmpt_timer #(.TMR_W(TMR_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .ld_en    (tmr_wr_en),
    .ld_data  (tmr_wr_data),
    .trig_evt (trig_evt),
    .cancel   (cmp_wr_en),
    .ovf_clr  (ovf_clr),
    .tmr_q    (tmr_q),
    .ovf_flag (ovf_flag)
  );

  cmpt_match #(.TMR_W(TMR_W)) u_match (
    .clk   (clk),
    .rst_n (rst_n),
    .tmr_q (tmr_q),
    .cmp_q (cmp_q),
    .hit   (hit)
  );

  cmpt_action u_action (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_wr_en   (ctl_wr_en),
    .ctl_wr_data (ctl_wr_data),
    .hit         (hit),
    .adc_en      (adc_en),
    .irq_clr     (irq_clr),
    .out_q       (cmp_out),
    .pin_oe      (pin_oe),
    .irq_flag    (irq_flag),
    .adc_start   (adc_start),
    .trig_evt    (trig_evt)
  );

  assign tmr_value = tmr_q;

  AST_ADC_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> (tmr_q == cmp_q)); // R7
endmodule

// File: tb/test_cmpt_unit.sv
module test_cmpt_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        tmr_wr_en = 1'b0;
  logic [15:0] tmr_wr_data = '0;
  logic        cmp_wr_en = 1'b0;
  logic [15:0] cmp_wr_data = '0;
  logic        ctl_wr_en = 1'b0;
  logic [3:0]  ctl_wr_data = '0;
  logic        adc_en = 1'b0;
  logic        irq_clr = 1'b0;
  logic        ovf_clr = 1'b0;
  logic [15:0] tmr_value;
  logic        cmp_out, pin_oe, irq_flag, ovf_flag, adc_start;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cmpt_unit i_cmpt_unit (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .tmr_wr_en(tmr_wr_en), .tmr_wr_data(tmr_wr_data),
    .cmp_wr_en(cmp_wr_en), .cmp_wr_data(cmp_wr_data),
    .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
    .adc_en(adc_en), .irq_clr(irq_clr), .ovf_clr(ovf_clr),
    .tmr_value(tmr_value), .cmp_out(cmp_out), .pin_oe(pin_oe),
    .irq_flag(irq_flag), .ovf_flag(ovf_flag), .adc_start(adc_start)
  );

  typedef struct packed {
    logic [3:0] mode;
    logic       adc;
    logic       exp_adc;
    logic       exp_oe;
    logic       exp_irq;
    logic       exp_out;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{4'b0010, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},
    '{4'b0010, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    '{4'b1000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},
    '{4'b1010, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
    '{4'b1001, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    '{4'b1000, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1},
    '{4'b1011, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
    '{4'b1011, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
    '{4'b0101, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
    '{4'b1001, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    '{4'b1111, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    tick_en = 0; tmr_wr_en = 0; cmp_wr_en = 0; ctl_wr_en = 0;
    irq_clr = 0; ovf_clr = 0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic load(input logic [15:0] t, input logic [15:0] c, input logic [3:0] m);
    tmr_wr_en = 1; tmr_wr_data = t;
    cmp_wr_en = 1; cmp_wr_data = c;
    ctl_wr_en = 1; ctl_wr_data = m;
    irq_clr = 1;
    step();
    idle();
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // Reset state
    chk("R12 reset timer", tmr_value, 0);
    chk("R5 reset latch", cmp_out, 0);
    chk("R4 reset irq", irq_flag, 0);
    chk("R10 reset ovf", ovf_flag, 0);
    chk("R11 reset oe", pin_oe, 0);

    // Table walk: one match per vector
    for (int i = 0; i < NV; i++) begin
      logic [15:0] c;
      c = 16'h0100 + 16'(i * 37);
      adc_en = VECS[i].adc;
      load(c - 16'd2, c, VECS[i].mode);
      chk($sformatf("R2/R3/R6/R7/R11 oe vec%0d", i), pin_oe, VECS[i].exp_oe);
      tick_en = 1;
      step();
      step();
      chk($sformatf("R12 timer at match vec%0d", i), tmr_value, c);
      chk($sformatf("R7 adc_start vec%0d", i), adc_start, VECS[i].exp_adc);
      tick_en = 0;
      step();
      chk($sformatf("R2/R3/R6 latch vec%0d", i), cmp_out, VECS[i].exp_out);
      chk($sformatf("R4/R11 irq vec%0d", i), irq_flag, VECS[i].exp_irq);
      // R1: held on matching value, no refire after clear
      irq_clr = 1;
      step();
      irq_clr = 0;
      step();
      step();
      chk($sformatf("R1 no refire vec%0d", i), irq_flag, 0);
      chk($sformatf("R1 latch held vec%0d", i), cmp_out, VECS[i].exp_out);
    end

    // R4: flag stays set until cleared
    load(16'd10, 16'd12, 4'b1010);
    tick_en = 1; step(); step(); tick_en = 0; step();
    repeat (4) step();
    chk("R4 irq sticky", irq_flag, 1);

    // R8: continuous ticks, timer restarts at edge after match
    adc_en = 1;
    load(16'd3, 16'd5, 4'b1011);
    tick_en = 1;
    step(); step();
    chk("R7 adc at match", adc_start, 1);
    step();
    chk("R8 restart to zero", tmr_value, 0);
    chk("R10 restart no ovf", ovf_flag, 0);
    step();
    chk("R8 count after restart", tmr_value, 1);
    chk("R1 adc one cycle", adc_start, 0);
    tick_en = 0;

    // R8: delayed tick
    load(16'd4, 16'd5, 4'b1011);
    tick_en = 1; step(); tick_en = 0;
    chk("R8 at match", tmr_value, 5);
    repeat (3) step();
    chk("R8 held while pending", tmr_value, 5);
    tick_en = 1; step(); tick_en = 0;
    chk("R8 delayed restart", tmr_value, 0);

    // R9: compare rewrite cancels pending restart
    load(16'd4, 16'd5, 4'b1011);
    tick_en = 1; step(); tick_en = 0;
    step();
    cmp_wr_en = 1; cmp_wr_data = 16'd9; step(); cmp_wr_en = 0;
    tick_en = 1; step(); tick_en = 0;
    chk("R9 restart cancelled", tmr_value, 6);

    // R10: wrap sets overflow, clear works
    load(16'hFFFE, 16'h1234, 4'b0000);
    tick_en = 1; step();
    chk("R10 no ovf before wrap", ovf_flag, 0);
    step(); tick_en = 0;
    chk("R10 wrapped value", tmr_value, 0);
    chk("R10 ovf set", ovf_flag, 1);
    step();
    chk("R10 ovf sticky", ovf_flag, 1);
    ovf_clr = 1; step(); ovf_clr = 0;
    chk("R10 ovf cleared", ovf_flag, 0);

    // R12: tick gating and load
    load(16'h0ABC, 16'h1234, 4'b0000);
    repeat (3) step();
    chk("R12 hold without tick", tmr_value, 16'h0ABC);
    tick_en = 1; step(); tick_en = 0;
    chk("R12 single tick", tmr_value, 16'h0ABD);

    // R5: mode write of zero forces latch low
    load(16'd20, 16'd21, 4'b1000);
    tick_en = 1; step(); tick_en = 0; step();
    chk("R3 latch set", cmp_out, 1);
    ctl_wr_en = 1; ctl_wr_data = 4'b0000; step(); idle();
    chk("R5 latch forced low", cmp_out, 0);
    chk("R11 oe off", pin_oe, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule